// File: doc/BRIEF.md
# Runahead Register File with Poison Tracking

This block is the integer register file of a pipeline that keeps executing past a cache miss instead of stalling. It holds two copies of every register. While `run_mode` is low (normal execution), each write lands in both copies and reads are served from the primary copy. While `run_mode` is high (runahead), the primary copy is frozen as the checkpoint, and all reads and writes work on the backup copy. When `run_mode` falls, every value produced during runahead is dropped at once. The pipeline then resumes from the primary copy without any bulk copy.

Each register also carries a poison (INV) flag that is meaningful only during runahead. The load that caused the miss poisons its destination through the mark port. Every runahead write carries the two source register numbers of its instruction. The destination inherits poison if either source is poisoned, and is cleaned if neither is.

After runahead ends, the backup copy no longer matches the primary for the registers that runahead touched. Those registers are copied back one per cycle in the background. Until a register has been copied back, a runahead read of it falls back to the primary copy. This makes it safe to re-enter runahead at any time.

Top module: `rahead_rf`

## Requirements
- R1: After reset every register reads as zero with its INV flag clear.
- R2: With `run_mode` low, a write updates the register and later reads return the written value. Read INV flags are always 0.
- R3: With `run_mode` high, reads return values written earlier in the same runahead episode. Registers not written in the episode return their value as of entry.
- R4: With `run_mode` high, a mark request sets the INV flag of the named register from the next cycle on. A mark request while `run_mode` is low has no effect on any later read.
- R5: A runahead write sets the destination INV flag when the stored INV flag of either source register is 1. It clears the flag when both are 0. When a mark and a write name the same register in one cycle, the mark wins.
- R6: Once `run_mode` falls, every register reads its value from before the runahead episode, and runahead writes leave no trace.
- R7: All INV flags are cleared when runahead ends. A later runahead episode starts with every flag at 0.
- R8: A runahead episode entered in any cycle after the previous one ends, including the very next cycle, sees the architectural values, even for registers the previous episode wrote.
- R9: A read of the register written in the same cycle returns the new data. During runahead it also returns the new INV flag, or 1 if that register is marked in the same cycle.
- R10: Register 0 always reads zero with INV 0. Writes and marks to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_mode | input | 1 | 1 = runahead, 0 = normal execution |
| mark_en | input | 1 | Poison request for a missing load's destination |
| mark_addr | input | AW | Register to poison |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write destination |
| wr_data | input | DW | Write data |
| wr_src0 | input | AW | First source register of the writing instruction (0 if unused) |
| wr_src1 | input | AW | Second source register of the writing instruction (0 if unused) |
| rd0_addr | input | AW | Read port 0 address |
| rd0_data | output | DW | Read port 0 data |
| rd0_inv | output | 1 | Read port 0 INV flag |
| rd1_addr | input | AW | Read port 1 address |
| rd1_data | output | DW | Read port 1 data |
| rd1_inv | output | 1 | Read port 1 INV flag |

## Verification
The hardest case to reach from the ports is re-entering runahead while the background copy-back from the previous episode is still running. In that state some backup entries are stale, and the read path must fall back to the primary copy register by register. The stimulus reaches it directly by writing several registers in runahead and leaving for one cycle. It then re-enters and reads those registers. The random phase also uses short normal intervals, so re-entry often lands mid copy-back with varying sets of stale registers.

// File: rtl/rahead_rf.sv
module rahead_rf #(
  parameter int NREGS = 32,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_mode,
  input  logic                     mark_en,
  input  logic [$clog2(NREGS)-1:0] mark_addr,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(NREGS)-1:0] wr_src0,
  input  logic [$clog2(NREGS)-1:0] wr_src1,
  input  logic [$clog2(NREGS)-1:0] rd0_addr,
  output logic [DW-1:0]            rd0_data,
  output logic                     rd0_inv,
  input  logic [$clog2(NREGS)-1:0] rd1_addr,
  output logic [DW-1:0]            rd1_data,
  output logic                     rd1_inv
);
  localparam int AW = $clog2(NREGS);

  logic [DW-1:0]    prim [NREGS];
  logic [DW-1:0]    bkup [NREGS];
  logic [NREGS-1:0] inv_q, inv_nx;
  logic [NREGS-1:0] stale_q, stale_nx;
  logic [NREGS-1:0] rawr_q, rawr_nx;
  logic [NREGS-1:0] pend;
  logic [AW-1:0]    cp_idx;
  logic             cp_vld;

  wire wr_go   = wr_en && (wr_addr != '0);
  wire mark_go = run_mode && mark_en && (mark_addr != '0);
  wire src_inv = inv_q[wr_src0] | inv_q[wr_src1];

  assign pend = stale_q | rawr_q;

  always_comb begin
    cp_vld = 1'b0;
    cp_idx = '0;
    for (int i = NREGS - 1; i > 0; i--) begin
      if (pend[i]) begin
        cp_vld = 1'b1;
        cp_idx = AW'(i);
      end
    end
  end

  always_comb begin
    inv_nx   = inv_q;
    rawr_nx  = rawr_q;
    stale_nx = stale_q;
    if (run_mode) begin
      if (wr_go) begin
        inv_nx[wr_addr]  = src_inv;
        rawr_nx[wr_addr] = 1'b1;
      end
      if (mark_go) inv_nx[mark_addr] = 1'b1;
    end else begin
      inv_nx   = '0;
      rawr_nx  = '0;
      stale_nx = pend;
      if (cp_vld) stale_nx[cp_idx] = 1'b0;
      if (wr_go)  stale_nx[wr_addr] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) begin
        prim[i] <= '0;
        bkup[i] <= '0;
      end
      inv_q   <= '0;
      rawr_q  <= '0;
      stale_q <= '0;
    end else begin
      inv_q   <= inv_nx;
      rawr_q  <= rawr_nx;
      stale_q <= stale_nx;
      if (!run_mode && cp_vld) bkup[cp_idx] <= prim[cp_idx];
      if (wr_go) begin
        bkup[wr_addr] <= wr_data;
        if (!run_mode) prim[wr_addr] <= wr_data;
      end
    end
  end

  function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
    if (a == '0)                       return '0;
    if (wr_go && wr_addr == a)         return wr_data;
    if (run_mode && !(stale_q[a] && !rawr_q[a])) return bkup[a];
    return prim[a];
  endfunction

  function automatic logic rd_flag(input logic [AW-1:0] a);
    if (a == '0 || !run_mode)      return 1'b0;
    if (mark_go && mark_addr == a) return 1'b1;
    if (wr_go && wr_addr == a)     return src_inv;
    return inv_q[a];
  endfunction

  assign rd0_data = rd_val(rd0_addr);
  assign rd1_data = rd_val(rd1_addr);
  assign rd0_inv  = rd_flag(rd0_addr);
  assign rd1_inv  = rd_flag(rd1_addr);

  logic [DW-1:0] prim_at_wr;
  assign prim_at_wr = prim[wr_addr];

  a_r6_ckpt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && wr_en) |=> (prim[$past(wr_addr)] == $past(prim_at_wr)));

  a_r4_mark_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && mark_en && mark_addr != '0) |=> inv_q[$past(mark_addr)]);

  a_r5_poison_prop: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && wr_en && wr_addr != '0 && src_inv) |=> inv_q[$past(wr_addr)]);

  a_r7_inv_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run_mode |=> (inv_q == '0));

  a_r2_normal_no_inv: assert property (@(posedge clk) disable iff (!rst_n)
    !run_mode |-> (!rd0_inv && !rd1_inv));

  a_r10_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_addr == '0) |-> (rd0_data == '0 && !rd0_inv));
endmodule

// File: tb/rahead_rf_tb_top.sv
module rahead_rf_tb_top;
  localparam int NR = 32;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, run_mode, mark_en, wr_en;
  logic [AW-1:0] mark_addr, wr_addr, wr_src0, wr_src1, rd0_addr, rd1_addr;
  logic [DW-1:0] wr_data, rd0_data, rd1_data;
  logic rd0_inv, rd1_inv;

  rahead_rf #(.NREGS(NR), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode),
    .mark_en(mark_en), .mark_addr(mark_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_src0(wr_src0), .wr_src1(wr_src1),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd0_inv(rd0_inv),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data), .rd1_inv(rd1_inv));

  logic [DW-1:0] arch [NR];
  logic [DW-1:0] ra   [NR];
  logic          minv [NR];
  bit prev_run;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] a);
    if (a == 0) return '0;
    if (wr_en && wr_addr == a) return wr_data;
    return run_mode ? ra[a] : arch[a];
  endfunction

  function automatic logic exp_inv(input logic [AW-1:0] a);
    if (a == 0 || !run_mode) return 1'b0;
    if (mark_en && mark_addr == a) return 1'b1;
    if (wr_en && wr_addr == a) return minv[wr_src0] | minv[wr_src1];
    return minv[a];
  endfunction

  task automatic check_port(input string tag, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic i);
    string t;
    t = (a == 0) ? "R10" : ((wr_en && wr_addr == a) ? "R9" : tag);
    checks++;
    if (d !== exp_data(a) || i !== exp_inv(a)) begin
      fails++;
      $display("FAIL %s reg=%0d data=%h inv=%b expected data=%h inv=%b",
               t, a, d, i, exp_data(a), exp_inv(a));
    end
  endtask

  task automatic step(input bit r, input bit w, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input logic [AW-1:0] s0,
                      input logic [AW-1:0] s1, input bit mk,
                      input logic [AW-1:0] ma, input logic [AW-1:0] a0,
                      input logic [AW-1:0] a1, input string tag);
    logic si;
    @(negedge clk);
    run_mode = r; wr_en = w; wr_addr = wa; wr_data = wd;
    wr_src0 = s0; wr_src1 = s1; mark_en = mk; mark_addr = ma;
    rd0_addr = a0; rd1_addr = a1;
    if (r && !prev_run)
      for (int k = 0; k < NR; k++) begin ra[k] = arch[k]; minv[k] = 1'b0; end
    #2;
    check_port(tag, a0, rd0_data, rd0_inv);
    check_port(tag, a1, rd1_data, rd1_inv);
    @(posedge clk);
    si = minv[s0] | minv[s1];
    if (r) begin
      if (w && wa != 0) begin ra[wa] = wd; minv[wa] = si; end
      if (mk && ma != 0) minv[ma] = 1'b1;
    end else begin
      if (w && wa != 0) arch[wa] = wd;
      for (int k = 0; k < NR; k++) minv[k] = 1'b0;
    end
    prev_run = r;
  endtask

  task automatic rd(input bit r, input logic [AW-1:0] a0,
                    input logic [AW-1:0] a1, input string tag);
    step(r, 0, 0, 0, 0, 0, 0, 0, a0, a1, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int k = 0; k < NR; k++) begin arch[k] = '0; ra[k] = '0; minv[k] = 0; end
    prev_run = 0;
    rst_n = 0; run_mode = 0; mark_en = 0; wr_en = 0; mark_addr = 0;
    wr_addr = 0; wr_data = 0; wr_src0 = 0; wr_src1 = 0; rd0_addr = 0; rd1_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    rd(0, 1, 31, "R1");
    rd(0, 17, 0, "R1");

    step(0, 1, 5, 32'hAAAA_0005, 0, 0, 0, 0, 5, 6, "R2");
    step(0, 1, 6, 32'hBBBB_0006, 0, 0, 0, 0, 6, 7, "R2");
    rd(0, 5, 6, "R2");
    step(0, 0, 0, 0, 0, 0, 1, 5, 5, 6, "R4");
    step(0, 1, 7, 32'h7777_0007, 0, 0, 0, 0, 7, 5, "R2");

    rd(1, 5, 6, "R4");
    step(1, 0, 0, 0, 0, 0, 1, 5, 1, 2, "R4");
    rd(1, 5, 6, "R4");
    step(1, 1, 7, 32'h1111_0007, 5, 0, 0, 0, 3, 4, "R5");
    step(1, 1, 8, 32'h2222_0008, 6, 0, 0, 0, 7, 8, "R5");
    rd(1, 7, 8, "R5");
    step(1, 1, 9, 32'h3333_0009, 0, 7, 1, 9, 9, 1, "R5");
    rd(1, 9, 7, "R5");
    step(1, 1, 5, 32'h4444_0005, 6, 6, 0, 0, 2, 3, "R5");
    step(1, 1, 6, 32'hDEAD_0006, 0, 0, 0, 0, 6, 5, "R3");
    rd(1, 6, 5, "R3");
    step(1, 1, 0, 32'hFFFF_FFFF, 5, 5, 1, 0, 0, 6, "R10");
    rd(1, 0, 7, "R10");

    rd(0, 6, 7, "R6");
    rd(1, 7, 6, "R8");
    rd(1, 5, 9, "R7");
    step(1, 1, 6, 32'h5555_0006, 0, 0, 0, 0, 6, 8, "R8");
    rd(0, 6, 8, "R6");
    rd(0, 5, 9, "R6");
    rd(1, 6, 8, "R8");
    rd(0, 0, 6, "R6");

    for (int n = 0; n < 4000; n++) begin
      bit r, w, mk;
      logic [AW-1:0] wa, s0, s1, ma, a0, a1;
      if ($urandom_range(0, 9) == 0) r = !prev_run; else r = prev_run;
      w  = $urandom_range(0, 2) != 0;
      mk = $urandom_range(0, 5) == 0;
      wa = AW'($urandom_range(0, 15));
      s0 = AW'($urandom_range(0, 15));
      s1 = AW'($urandom_range(0, 15));
      ma = AW'($urandom_range(0, 15));
      a0 = ($urandom_range(0, 3) == 0) ? wa : AW'($urandom_range(0, 15));
      a1 = ($urandom_range(0, 3) == 0) ? ma : AW'($urandom_range(0, 15));
      step(r, w, wa, DW'($urandom), s0, s1, mk, ma, a0, a1, r ? "R3" : "R2");
    end
    finish_run();
  end
endmodule